// File: doc/BRIEF.md
# FIFO Protocol and Ordering Monitor

This block is a passive, synthesizable observer placed next to a single-clock FIFO. It reads only the FIFO's port-level signals: write enable and write data, read enable and read data, the full and empty flags, and the occupancy count. It drives nothing back into the FIFO. From the transfers that the FIFO actually accepted, it rebuilds its own write and read pointers and a shadow occupancy. It then checks every cycle that the FIFO's flags, its count and its read data agree with those transfers.

The monitor does not keep a copy of the whole queue. It checks first-in first-out ordering through a single tracked slot. A static input names one pointer value, one bit wider than the memory address. When the write pointer reaches that value, the monitor stores the word written. When the read pointer reaches the same value, it expects that word on the read data one cycle after the read.

A violation sets a sticky error flag and a code that names the rule that broke first. Both stay until reset. Stimulus generation and full-memory modelling are left to other blocks.

Top module: `fifo_order_monitor`

## Requirements
- R1: A synchronous active-high reset clears all shadow state, `err_flag` and `err_code` (0). No rule is evaluated while reset is high, nor in the first cycle after reset is released.
- R2: A write counts as accepted only when write enable is high and full is low. A read counts as accepted only when read enable is high and empty is low. Refused requests (a write while full, a read while empty) raise no error.
- R3: Full and empty high in the same cycle is violation code 1.
- R4: A count port value above DEPTH is violation code 2.
- R5: A count that differs from its previous-cycle value by more than one is violation code 3.
- R6: Empty seen in the cycle after an accepted write is code 4. Full seen in the cycle after an accepted read is code 5.
- R7: Empty differing from (count == 0) is code 6. Full differing from (count == DEPTH) is code 7.
- R8: A count port differing from the shadow occupancy (accepted writes minus accepted reads, modulo 2·DEPTH) is code 8.
- R9: Rule 9 follows one slot. When an accepted write occurs with the shadow write pointer (width log2(DEPTH)+1) equal to `track_idx`, the monitor stores the data. When the accepted read with the shadow read pointer equal to `track_idx` arrives, the read data in the following cycle must equal the stored word, or code 9 results. This works across pointer wrap.
- R10: `err_flag` is sticky until reset. `err_code` keeps the code of the first failing cycle. When several rules fail in that cycle, the lowest code wins.
- R11: Flag and code are registered. A violation present during cycle N is visible on both outputs right after the clock edge that ends cycle N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the observed FIFO |
| rst | input | 1 | Synchronous active-high reset |
| track_idx | input | log2(DEPTH)+1 | Static pointer value of the slot followed for ordering |
| mon_wr_en | input | 1 | Observed write enable |
| mon_wr_data | input | DATA_W | Observed write data |
| mon_rd_en | input | 1 | Observed read enable |
| mon_rd_data | input | DATA_W | Observed registered read data |
| mon_full | input | 1 | Observed full flag |
| mon_empty | input | 1 | Observed empty flag |
| mon_count | input | log2(DEPTH)+1 | Observed occupancy |
| err_flag | output | 1 | Sticky violation indicator |
| err_code | output | 4 | First violated rule (0 = none, 1 to 9 as listed) |

## Verification
The bench drives a well-behaved behavioural FIFO and corrupts one of its outputs for a single cycle. Several of these corruptions break more than one rule at once (full and empty together, or a count jump past DEPTH), so a monitor with the wrong priority order would report a higher code than expected. Refused writes at full and refused reads at empty must leave the monitor silent; a monitor that counted requests instead of accepted transfers would flag a false shadow mismatch. The tracked slot is placed beyond the first pointer lap, and one run feeds inverted read data, so a tracker that matched only the address bits, or never compared at all, is exposed. A further run forces conflicting flags across the reset release to show that the mask covers the first cycle after reset.

// File: rtl/fmon_pkg.sv
package fmon_pkg;
  localparam int NUM_RULES = 9;
  localparam int CODE_W    = 4;

  // bit index in the violation vector; reported code is index + 1
  localparam int IDX_BOTH     = 0;
  localparam int IDX_RANGE    = 1;
  localparam int IDX_STEP     = 2;
  localparam int IDX_WR_EMPTY = 3;
  localparam int IDX_RD_FULL  = 4;
  localparam int IDX_EMPTY_CT = 5;
  localparam int IDX_FULL_CT  = 6;
  localparam int IDX_SHADOW   = 7;
  localparam int IDX_ORDER    = 8;

  typedef logic [NUM_RULES-1:0] viol_t;
endpackage

// File: rtl/fmon_shadow.sv
module fmon_shadow #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             full,
  input  logic             empty,
  input  logic [PTR_W-1:0] count,
  output logic             wr_acc,
  output logic             rd_acc,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [PTR_W-1:0] shadow_cnt,
  output logic [PTR_W-1:0] prev_count,
  output logic             prev_wr,
  output logic             prev_rd,
  output logic             armed
);
  assign wr_acc     = wr_en && !full;
  assign rd_acc     = rd_en && !empty;
  assign shadow_cnt = wptr - rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      prev_count <= '0;
      prev_wr    <= 1'b0;
      prev_rd    <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (wr_acc) wptr <= wptr + 1'b1;
      if (rd_acc) rptr <= rptr + 1'b1;
      prev_count <= count;
      prev_wr    <= wr_acc;
      prev_rd    <= rd_acc;
      armed      <= 1'b1;
    end
  end

  // R2
  wptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_acc |=> $stable(wptr));
  // R2
  rptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> (rptr == $past(rptr) + 1'b1));
endmodule

// File: rtl/fmon_rules.sv
module fmon_rules
  import fmon_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 4
) (
  input  logic             full,
  input  logic             empty,
  input  logic [PTR_W-1:0] count,
  input  logic [PTR_W-1:0] prev_count,
  input  logic [PTR_W-1:0] shadow_cnt,
  input  logic             prev_wr,
  input  logic             prev_rd,
  input  logic             ord_bad,
  output viol_t            viol
);
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);

  logic [PTR_W-1:0] delta;

  always_comb begin
    delta = (count >= prev_count) ? (count - prev_count) : (prev_count - count);
    viol               = '0;
    viol[IDX_BOTH]     = full && empty;
    viol[IDX_RANGE]    = count > FULL_CNT;
    viol[IDX_STEP]     = delta > ONE;
    viol[IDX_WR_EMPTY] = prev_wr && empty;
    viol[IDX_RD_FULL]  = prev_rd && full;
    viol[IDX_EMPTY_CT] = empty != (count == '0);
    viol[IDX_FULL_CT]  = full != (count == FULL_CNT);
    viol[IDX_SHADOW]   = count != shadow_cnt;
    viol[IDX_ORDER]    = ord_bad;
  end
endmodule

// File: rtl/fmon_tracker.sv
module fmon_tracker #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_acc,
  input  logic              rd_acc,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [PTR_W-1:0]  track_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic              ord_bad
);
  logic [DATA_W-1:0] held_q;
  logic              pend_q;
  logic              chk_q;
  logic              wr_hit;
  logic              rd_hit;

  assign wr_hit  = wr_acc && (wptr == track_idx);
  assign rd_hit  = rd_acc && pend_q && (rptr == track_idx);
  assign ord_bad = chk_q && (rd_data != held_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      pend_q <= 1'b0;
      chk_q  <= 1'b0;
    end else begin
      chk_q <= rd_hit;
      if (wr_hit) begin
        held_q <= wr_data;
        pend_q <= 1'b1;
      end else if (rd_hit) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R9
  order_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    chk_q |-> $past(rd_acc));
endmodule

// File: rtl/fmon_latch.sv
module fmon_latch
  import fmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  viol_t             viol,
  output logic              err_flag,
  output logic [CODE_W-1:0] err_code
);
  logic [CODE_W-1:0] first_code;

  always_comb begin
    first_code = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (viol[i]) first_code = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_code <= '0;
    end else if (armed && !err_flag && (|viol)) begin
      err_flag <= 1'b1;
      err_code <= first_code;
    end
  end

  // R11
  trip_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (|viol)) |=> err_flag);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> $stable(err_code));
  // R1
  mask_window_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !err_flag);
endmodule

// File: rtl/fifo_order_monitor.sv
module fifo_order_monitor
  import fmon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  track_idx,
  input  logic              mon_wr_en,
  input  logic [DATA_W-1:0] mon_wr_data,
  input  logic              mon_rd_en,
  input  logic [DATA_W-1:0] mon_rd_data,
  input  logic              mon_full,
  input  logic              mon_empty,
  input  logic [PTR_W-1:0]  mon_count,
  output logic              err_flag,
  output logic [CODE_W-1:0] err_code
);
  logic             wr_acc, rd_acc;
  logic [PTR_W-1:0] wptr, rptr, shadow_cnt, prev_count;
  logic             prev_wr, prev_rd, armed;
  logic             ord_bad;
  viol_t            viol;

  fmon_shadow #(.PTR_W(PTR_W)) shadow_i (
    .clk(clk), .rst(rst), .wr_en(mon_wr_en), .rd_en(mon_rd_en),
    .full(mon_full), .empty(mon_empty), .count(mon_count),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wptr(wptr), .rptr(rptr),
    .shadow_cnt(shadow_cnt), .prev_count(prev_count),
    .prev_wr(prev_wr), .prev_rd(prev_rd), .armed(armed)
  );

  fmon_tracker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) tracker_i (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .wptr(wptr), .rptr(rptr), .track_idx(track_idx),
    .wr_data(mon_wr_data), .rd_data(mon_rd_data), .ord_bad(ord_bad)
  );

  fmon_rules #(.DEPTH(DEPTH), .PTR_W(PTR_W)) rules_i (
    .full(mon_full), .empty(mon_empty), .count(mon_count),
    .prev_count(prev_count), .shadow_cnt(shadow_cnt),
    .prev_wr(prev_wr), .prev_rd(prev_rd), .ord_bad(ord_bad), .viol(viol)
  );

  fmon_latch latch_i (
    .clk(clk), .rst(rst), .armed(armed), .viol(viol),
    .err_flag(err_flag), .err_code(err_code)
  );
endmodule

// File: tb/fifo_order_monitor_tb.sv
`timescale 1ns/1ps
module fifo_order_monitor_tb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int CW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] track_idx = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          err_flag;
  logic [3:0]    err_code;

  // behavioural reference FIFO plus fault knobs
  logic [DW-1:0] mem [DEPTH];
  int            wp, rp, cnt;
  logic [DW-1:0] rdata;
  logic          f_full = 1'b0, f_empty = 1'b0, f_cset = 1'b0;
  int            f_cadd = 0;
  logic [CW-1:0] f_cval = '0;
  logic [DW-1:0] f_xor = '0;
  logic          wa, ra;
  logic          m_full, m_empty;
  logic [CW-1:0] m_count;
  logic [DW-1:0] m_rdata;

  int nchk = 0, nerr = 0;
  logic [DW-1:0] seq = 8'h10;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign wa      = wr_en && (cnt != DEPTH);
  assign ra      = rd_en && (cnt != 0);
  assign m_full  = (cnt == DEPTH) | f_full;
  assign m_empty = (cnt == 0) | f_empty;
  assign m_count = f_cset ? f_cval : CW'(cnt + f_cadd);
  assign m_rdata = rdata ^ f_xor;

  always @(posedge clk) begin
    if (rst) begin
      wp <= 0; rp <= 0; cnt <= 0; rdata <= '0;
    end else begin
      if (wa) begin mem[wp % DEPTH] <= wr_data; wp <= wp + 1; end
      if (ra) begin rdata <= mem[rp % DEPTH]; rp <= rp + 1; end
      cnt <= cnt + (wa ? 1 : 0) - (ra ? 1 : 0);
    end
  end

  fifo_order_monitor #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .track_idx(track_idx),
    .mon_wr_en(wr_en), .mon_wr_data(wr_data), .mon_rd_en(rd_en),
    .mon_rd_data(m_rdata), .mon_full(m_full), .mon_empty(m_empty),
    .mon_count(m_count), .err_flag(err_flag), .err_code(err_code)
  );

  // kind, fill level, tracked index, expected code
  localparam int NSC = 10;
  localparam int TBL [NSC][4] = '{
    '{0, 5, 13, 0}, '{1, 3, 2, 1}, '{2, 3, 2, 2}, '{3, 3, 2, 3},
    '{4, 3, 2, 4},  '{5, 8, 2, 5}, '{6, 3, 2, 6}, '{7, 3, 2, 7},
    '{8, 3, 2, 8},  '{9, 3, 13, 9}
  };

  function automatic string tag_of(input int k);
    case (k)
      0: return "R9 clean wrap";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6, 7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r);
    wr_en = w; rd_en = r; wr_data = seq;
    if (w && cnt != DEPTH) seq = seq + 8'd1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) cyc(1'b0, 1'b0);
    rst = 1'b0;
    repeat (2) cyc(1'b0, 1'b0);
  endtask

  task automatic apply_fault(input int kind);
    cyc(1'b0, 1'b0);
    case (kind)
      1: begin f_full = 1; f_empty = 1; cyc(0, 0); f_full = 0; f_empty = 0; end
      2: begin f_cset = 1; f_cval = CW'(DEPTH + 3); cyc(0, 0); f_cset = 0; end
      3: begin f_cadd = 3; cyc(0, 0); f_cadd = 0; end
      4: begin cyc(1, 0); f_empty = 1; cyc(0, 0); f_empty = 0; end
      5: begin cyc(0, 1); f_full = 1; cyc(0, 0); f_full = 0; end
      6: begin f_empty = 1; cyc(0, 0); f_empty = 0; end
      7: begin f_full = 1; cyc(0, 0); f_full = 0; end
      8: begin f_cadd = 1; cyc(0, 0); f_cadd = 0; end
      default: ;
    endcase
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state and masking of the first cycle after release
    f_full = 1; f_empty = 1;
    rst = 1'b1;
    repeat (3) cyc(0, 0);
    check("R1 flag in reset", err_flag, 0);
    rst = 1'b0;
    cyc(0, 0);
    f_full = 0; f_empty = 0;
    repeat (2) cyc(0, 0);
    check("R1 masked flag", err_flag, 0);
    check("R1 masked code", err_code, 0);

    // table of fault scenarios
    for (int i = 0; i < NSC; i++) begin
      track_idx = CW'(TBL[i][2]);
      do_reset();
      repeat (TBL[i][1]) cyc(1, 0);
      apply_fault(TBL[i][0]);
      if (TBL[i][0] == 9) f_xor = 8'hFF;
      repeat (24) cyc(1, 1);
      repeat (10) cyc(0, 1);
      f_xor = '0;
      cyc(0, 0);
      check({tag_of(TBL[i][0]), " flag"}, err_flag, (TBL[i][3] != 0) ? 1 : 0);
      check({tag_of(TBL[i][0]), " code"}, err_code, TBL[i][3]);
    end

    // R2: refused requests at both boundaries stay silent
    track_idx = 4'd1;
    do_reset();
    repeat (2) cyc(0, 1);
    repeat (DEPTH) cyc(1, 0);
    repeat (3) cyc(1, 0);
    repeat (DEPTH) cyc(0, 1);
    repeat (2) cyc(0, 1);
    cyc(0, 0);
    check("R2 refused flag", err_flag, 0);
    check("R2 refused code", err_code, 0);

    // R11 latency, R10 sticky and first code
    do_reset();
    repeat (3) cyc(1, 0);
    cyc(0, 0);
    check("R11 before edge", err_flag, 0);
    f_cadd = 1;
    cyc(0, 0);
    f_cadd = 0;
    check("R11 flag after edge", err_flag, 1);
    check("R11 code after edge", err_code, 8);
    f_full = 1; f_empty = 1; cyc(0, 0); f_full = 0; f_empty = 0;
    repeat (5) cyc(1, 1);
    check("R10 sticky flag", err_flag, 1);
    check("R10 first code kept", err_code, 8);

    // R1: reset clears a latched error
    do_reset();
    check("R1 clear flag", err_flag, 0);
    check("R1 clear code", err_code, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule